// File: doc/BRIEF.md
# Timer trigger and slave-mode controller

This block pairs a general-purpose up-counter with the logic that lets one external event steer it. A 3-bit source field picks one of eight trigger signals. Four come from other timers. One is a transition detector on conditioned input 1. The others are conditioned input 1, conditioned input 2 and an external trigger pin with selectable polarity. A 3-bit action field decides what the chosen trigger does to the counter. It can do nothing, restart the counter, gate its counting, start it once, or clock it directly.

Software programs the source and action through one 8-bit configuration write port and reads the stored value back. The count enable has its own write strobe. The counter runs from zero up to a reload value, then wraps to zero, and each restart raises a one-cycle update pulse. Rising edges of the trigger are found against a registered copy of it. A trigger change driven before a clock edge therefore takes effect on the counter at that edge, and is visible from the following cycle.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: The source field (configuration bits 6:4) picks the trigger as follows: 0 to 3 pick internal trigger 0 to 3, 4 picks the input-1 transition detector, 5 picks input 1, 6 picks input 2, and 7 picks the external trigger. A non-selected input has no effect.
- R2: With source 4, every transition of input 1, rising or falling, yields one trigger pulse. In clock action this means two counts per full high/low pulse.
- R3: With action 000 (bits 2:0) and the enable set, the counter advances by one on every clock, and trigger activity is ignored.
- R4: With action 100, a trigger rising edge sets the counter to zero and raises the update pulse at the same edge. A trigger that stays high does not restart the counter again.
- R5: With action 101 and the enable set, the counter advances on each clock while the trigger is high. It holds its value, without clearing, while the trigger is low.
- R6: With action 110, a trigger rising edge sets the count enable and leaves the count unchanged. Counting begins on the next clock and goes on after the trigger falls.
- R7: With action 111 and the enable set, each trigger rising edge advances the counter by exactly one.
- R8: When the polarity input is 1, the external trigger is inverted before use, so its falling edge is the active edge.
- R9: The configuration read-back shows the source in bits 6:4 and the action in bits 2:0. Bits 3 and 7 always read 0.
- R10: A configuration write is dropped whole when the stored action is not 000 and the written source differs from the stored one.
- R11: When the counter advances while it equals the reload value, it wraps to zero and the update output pulses high for exactly that one cycle.
- R12: After reset, the count, count enable, update output and configuration read-back are all zero.
- R13: Actions 001 to 011 behave as action 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data: source in 6:4, action in 2:0 |
| cfg_rdata | output | 8 | Stored configuration, reserved bits zero |
| en_we | input | 1 | Count enable write strobe |
| en_d | input | 1 | Count enable write value |
| cnt_en | output | 1 | Current count enable |
| reload | input | CNT_W | Terminal count value |
| itr | input | 4 | Internal triggers 0 to 3 |
| ti1f | input | 1 | Conditioned timer input 1 |
| ti2f | input | 1 | Conditioned timer input 2 |
| etr | input | 1 | External trigger |
| etr_pol | input | 1 | External trigger inversion |
| cnt_q | output | CNT_W | Counter value |
| upd | output | 1 | Update event pulse |

## Verification
On every cycle, the assertions check several rules. The reserved read-back bits must stay zero. A blocked source write must leave the configuration untouched. An update pulse must coincide with a zero count. The count may only hold, step by one or return to zero. Gated action with a low trigger must freeze the count, a trigger edge in restart action must clear the counter, and one in start action must set the enable. Other properties need the bench's scenarios. These are the mapping of each source code to its input, the double count per pulse from the transition detector, and the inverted external trigger. They also include that a held-high trigger restarts only once, that a count survives a start, and the exact wrap point against the reload value.

// File: rtl/tmr_slave_pkg.sv
// Shared types for the timer trigger and slave-mode controller.
// Assumes a 3-bit source field; internal trigger count follows from it.
package tmr_slave_pkg;
    localparam int SEL_W = 3;
    localparam int N_SRC = 2 ** SEL_W;
    localparam int N_ITR = N_SRC - 4;

    typedef enum logic [2:0] {
        ACT_OFF     = 3'b000,
        ACT_QUAD1   = 3'b001,
        ACT_QUAD2   = 3'b010,
        ACT_QUAD3   = 3'b011,
        ACT_RESTART = 3'b100,
        ACT_GATE    = 3'b101,
        ACT_START   = 3'b110,
        ACT_EXTCLK  = 3'b111
    } slave_act_e;
endpackage

// File: rtl/tsc_trig_select.sv
// Trigger source multiplexer. It builds the transition detector on input 1,
// applies external-trigger polarity and selects one source.
// Assumes the inputs are already synchronous to clk.
module tsc_trig_select
    import tmr_slave_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ITR-1:0] itr,
    input  logic             ti1f,
    input  logic             ti2f,
    input  logic             etr,
    input  logic             etr_pol,
    input  logic [SEL_W-1:0] sel,
    output logic             trgi
);
    logic             ti1_d;
    logic             ti1_chg;
    logic [N_SRC-1:0] src;

    // Hold last input-1 level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ti1_d <= 1'b0;
        else        ti1_d <= ti1f;
    end

    assign ti1_chg = ti1f ^ ti1_d;

    for (genvar g = 0; g < N_ITR; g++) begin : g_itr
        assign src[g] = itr[g];
    end
    assign src[N_ITR]     = ti1_chg;
    assign src[N_ITR + 1] = ti1f;
    assign src[N_ITR + 2] = ti2f;
    assign src[N_ITR + 3] = etr ^ etr_pol;

    // Pick the configured source.
    always_comb trgi = src[sel];
endmodule

// File: rtl/tsc_edge_det.sv
// Rising-edge finder for the selected trigger. It compares against a
// registered copy, so an edge is seen in the cycle the trigger first reads high.
module tsc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic trgi,
    output logic rise
);
    logic trgi_d;

    // Registered copy of the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) trgi_d <= 1'b0;
        else        trgi_d <= trgi;
    end

    assign rise = trgi & ~trgi_d;
endmodule

// File: rtl/tsc_mode_ctrl.sv
// Configuration and enable registers plus the per-action decode of counter
// tick and restart. Assumes a source change is only legal while the action is off.
module tsc_mode_ctrl
    import tmr_slave_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic             en_we,
    input  logic             en_d,
    input  logic             trgi,
    input  logic             rise,
    output logic [SEL_W-1:0] sel,
    output logic [7:0]       cfg_rdata,
    output logic             cnt_en,
    output logic             tick,
    output logic             restart
);
    slave_act_e       act_q;
    logic [SEL_W-1:0] sel_q;
    logic             en_q;
    logic             wr_block;

    assign wr_block = (act_q != ACT_OFF) && (cfg_wdata[6:4] != sel_q);

    // Store configuration unless the write would move the source mid-use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= ACT_OFF;
            sel_q <= '0;
        end else if (cfg_we && !wr_block) begin
            act_q <= slave_act_e'(cfg_wdata[2:0]);
            sel_q <= cfg_wdata[6:4];
        end
    end

    // Count enable: software write wins, start action may set it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 en_q <= 1'b0;
        else if (en_we)                             en_q <= en_d;
        else if (act_q == ACT_START && rise)        en_q <= 1'b1;
    end

    // Decode how the trigger steers the counter this cycle.
    always_comb begin
        restart = 1'b0;
        case (act_q)
            ACT_RESTART: begin
                tick    = en_q;
                restart = rise;
            end
            ACT_GATE:    tick = en_q & trgi;
            ACT_EXTCLK:  tick = en_q & rise;
            default:     tick = en_q;
        endcase
    end

    assign sel       = sel_q;
    assign cnt_en    = en_q;
    assign cfg_rdata = {1'b0, sel_q, 1'b0, act_q};
endmodule

// File: rtl/tsc_counter.sv
// Up-counter with reload wrap and update pulse. Assumes restart has priority
// over a tick in the same cycle.
module tsc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload,
    input  logic             tick,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt_q,
    output logic             upd
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    // Advance, wrap or restart the count; flag each return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            upd   <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (restart) begin
                cnt_q <= '0;
                upd   <= 1'b1;
            end else if (tick) begin
                if (cnt_q == reload) begin
                    cnt_q <= '0;
                    upd   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + STEP;
                end
            end
        end
    end
endmodule

// File: rtl/tmr_slave_ctrl.sv
// Top of the timer trigger and slave-mode controller: source select, edge
// finder, action decode and counter. Assumes all inputs are synchronous to clk.
module tmr_slave_ctrl
    import tmr_slave_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             en_we,
    input  logic             en_d,
    output logic             cnt_en,
    input  logic [CNT_W-1:0] reload,
    input  logic [3:0]       itr,
    input  logic             ti1f,
    input  logic             ti2f,
    input  logic             etr,
    input  logic             etr_pol,
    output logic [CNT_W-1:0] cnt_q,
    output logic             upd
);
    logic [SEL_W-1:0] sel;
    logic             trgi;
    logic             trg_rise;
    logic             tick;
    logic             restart;

    tsc_trig_select u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .itr     (itr),
        .ti1f    (ti1f),
        .ti2f    (ti2f),
        .etr     (etr),
        .etr_pol (etr_pol),
        .sel     (sel),
        .trgi    (trgi)
    );

    tsc_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .trgi  (trgi),
        .rise  (trg_rise)
    );

    tsc_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .en_we     (en_we),
        .en_d      (en_d),
        .trgi      (trgi),
        .rise      (trg_rise),
        .sel       (sel),
        .cfg_rdata (cfg_rdata),
        .cnt_en    (cnt_en),
        .tick      (tick),
        .restart   (restart)
    );

    tsc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (reload),
        .tick    (tick),
        .restart (restart),
        .cnt_q   (cnt_q),
        .upd     (upd)
    );
endmodule

// File: rtl/tmr_slave_ctrl_chk.sv
// Property checker for the controller, attached to every instance by bind.
module tmr_slave_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [2:0]       wr_sel,
    input logic [7:0]       cfg_rdata,
    input logic             en_we,
    input logic             cnt_en,
    input logic             trgi,
    input logic             rise,
    input logic [CNT_W-1:0] cnt_q,
    input logic             upd
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[3] == 1'b0 && cfg_rdata[7] == 1'b0); // R9

    AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_rdata[2:0] != 3'b000 && wr_sel != cfg_rdata[6:4])
        |=> $stable(cfg_rdata)); // R10

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> cnt_q == '0); // R11

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE
                  || cnt_q == '0)); // R7

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2:0] == 3'b101 && !trgi) |=> $stable(cnt_q)); // R5

    AST_RESTART_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2:0] == 3'b100 && rise) |=> (cnt_q == '0 && upd)); // R4

    AST_START_SETS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2:0] == 3'b110 && rise && !en_we) |=> cnt_en); // R6
endmodule

bind tmr_slave_ctrl tmr_slave_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .wr_sel    (cfg_wdata[6:4]),
    .cfg_rdata (cfg_rdata),
    .en_we     (en_we),
    .cnt_en    (cnt_en),
    .trgi      (trgi),
    .rise      (trg_rise),
    .cnt_q     (cnt_q),
    .upd       (upd)
);

// File: tb/tmr_slave_ctrl_bench.sv
// Self-checking bench: a vector table for source selection in clock action,
// then directed scenarios for each action and corner case.
module tmr_slave_ctrl_bench;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [7:0]       cfg_wdata = '0;
    logic [7:0]       cfg_rdata;
    logic             en_we = 1'b0;
    logic             en_d = 1'b0;
    logic             cnt_en;
    logic [CNT_W-1:0] reload = 16'd1000;
    logic [3:0]       itr = '0;
    logic             ti1f = 1'b0;
    logic             ti2f = 1'b0;
    logic             etr = 1'b0;
    logic             etr_pol = 1'b0;
    logic [CNT_W-1:0] cnt_q;
    logic             upd;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tmr_slave_ctrl #(.CNT_W(CNT_W)) u_tmr_slave_ctrl (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata), .en_we (en_we), .en_d (en_d), .cnt_en (cnt_en),
        .reload (reload), .itr (itr), .ti1f (ti1f), .ti2f (ti2f), .etr (etr),
        .etr_pol (etr_pol), .cnt_q (cnt_q), .upd (upd)
    );

    // Vector: {source field, input to pulse, expected count after 3 pulses}.
    // Input index: 0..3 internal triggers, 4 input 1, 5 input 2, 6 external.
    localparam logic [9:0] VEC [10] = '{
        {3'd0, 3'd0, 4'd3}, {3'd1, 3'd1, 4'd3}, {3'd2, 3'd2, 4'd3},
        {3'd3, 3'd3, 4'd3}, {3'd0, 3'd1, 4'd0}, {3'd4, 3'd4, 4'd6},
        {3'd5, 3'd4, 4'd3}, {3'd6, 3'd5, 4'd3}, {3'd7, 3'd6, 4'd3},
        {3'd5, 3'd5, 4'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_we = 1'b0; en_we = 1'b0; itr = '0; ti1f = 1'b0; ti2f = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_en(input logic v);
        en_we = 1'b1; en_d = v;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic set_src(input int idx, input logic v);
        case (idx)
            0, 1, 2, 3: itr[idx] = v;
            4:          ti1f = v;
            5:          ti2f = v;
            default:    etr = v;
        endcase
    endtask

    task automatic pulse_src(input int idx);
        set_src(idx, 1'b1);
        repeat (2) @(negedge clk);
        set_src(idx, 1'b0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 count", int'(cnt_q), 0);
        chk("R12 enable", int'(cnt_en), 0);
        chk("R12 update", int'(upd), 0);
        chk("R12 config", int'(cfg_rdata), 0);

        // R1 / R2 / R7: source table in clock action
        for (int i = 0; i < 10; i++) begin
            do_reset();
            wr_cfg({1'b0, VEC[i][9:7], 1'b0, 3'b111});
            wr_en(1'b1);
            repeat (3) pulse_src(int'(VEC[i][6:4]));
            chk((VEC[i][9:7] == 3'd4) ? "R2 edge source" : "R1 R7 source",
                int'(cnt_q), int'(VEC[i][3:0]));
        end

        // R9 / R10: read-back layout and locked source
        do_reset();
        wr_cfg(8'hFF);
        chk("R9 readback", int'(cfg_rdata), 8'h77);
        wr_cfg(8'h07);
        chk("R10 blocked write", int'(cfg_rdata), 8'h77);
        wr_cfg(8'h75);
        chk("R10 same source", int'(cfg_rdata), 8'h75);
        wr_cfg(8'h70);
        wr_cfg(8'h03);
        chk("R10 off then change", int'(cfg_rdata), 8'h03);

        // R3: free running, triggers ignored
        do_reset();
        wr_en(1'b1);
        itr = 4'hF;
        repeat (5) @(negedge clk);
        chk("R3 free run", int'(cnt_q), 5);
        itr = '0;

        // R13: quadrature codes act as off
        do_reset();
        wr_cfg(8'h02);
        wr_en(1'b1);
        repeat (4) @(negedge clk);
        chk("R13 code 010", int'(cnt_q), 4);

        // R11: wrap at reload
        do_reset();
        reload = 16'd3;
        wr_en(1'b1);
        repeat (4) @(negedge clk);
        chk("R11 wrap count", int'(cnt_q), 0);
        chk("R11 wrap update", int'(upd), 1);
        @(negedge clk);
        chk("R11 after wrap", int'(cnt_q), 1);
        chk("R11 pulse width", int'(upd), 0);
        reload = 16'd1000;

        // R4: restart action
        do_reset();
        wr_cfg(8'h04);
        wr_en(1'b1);
        repeat (5) @(negedge clk);
        chk("R4 before", int'(cnt_q), 5);
        itr[0] = 1'b1;
        @(negedge clk);
        chk("R4 cleared", int'(cnt_q), 0);
        chk("R4 update", int'(upd), 1);
        @(negedge clk);
        chk("R4 held high", int'(cnt_q), 1);
        itr[0] = 1'b0;

        // R5: gated action
        do_reset();
        wr_cfg(8'h15);
        wr_en(1'b1);
        repeat (4) @(negedge clk);
        chk("R5 gate low", int'(cnt_q), 0);
        itr[1] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 gate high", int'(cnt_q), 3);
        itr[1] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 hold", int'(cnt_q), 3);

        // R6: start action keeps the count
        do_reset();
        wr_en(1'b1);
        repeat (4) @(negedge clk);
        wr_en(1'b0);
        wr_cfg(8'h26);
        repeat (2) @(negedge clk);
        chk("R6 idle count", int'(cnt_q), 5);
        chk("R6 idle enable", int'(cnt_en), 0);
        itr[2] = 1'b1;
        @(negedge clk);
        chk("R6 enable set", int'(cnt_en), 1);
        chk("R6 count kept", int'(cnt_q), 5);
        repeat (3) @(negedge clk);
        itr[2] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 runs on", int'(cnt_q), 10);

        // R8: inverted external trigger
        etr_pol = 1'b1; etr = 1'b1;
        do_reset();
        wr_cfg(8'h77);
        wr_en(1'b1);
        chk("R8 idle", int'(cnt_q), 0);
        etr = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 falling counts", int'(cnt_q), 1);
        etr = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 rising ignored", int'(cnt_q), 1);
        etr_pol = 1'b0; etr = 1'b0;

        summary();
    end
endmodule